// File: doc/BRIEF.md
# Sector-Paced Job Swap Sequencer

This block copies one complete job image of 4096 words between memory and a disk that can only move a single 256-word sector per command. The image occupies one disk track of 16 sectors. After a start pulse, the block issues sixteen sector commands back to back. It waits for the disk's completion interrupt after each one before it starts the next. For every command it steps both the sector index and the memory address.

The start pulse carries five settings:
- the direction: swap-out writes memory to disk, swap-in reads disk into memory;
- the track number;
- the 3-bit memory field;
- an optional pending swap-in;
- the track and field of that pending swap-in.

When a swap-out ends and a swap-in is pending, the block goes straight on into the swap-in, with no new start pulse. A completion that reports an error stops the sequence at once and raises an error pulse. A normal finish raises a done pulse.

Top module: `swap_seq`

## Requirements
- R1: After reset, `busy`, `go`, `done` and `err` are all low.
- R2: A start accepted while idle makes the command, disk address and memory address valid in the next cycle. `go` is a single-cycle pulse in the cycle after that. The same timing applies to every later command.
- R3: The command word is defined bit by bit:
  - bit 11 is 1 for swap-out (write) and 0 for swap-in (read);
  - bit 9 is 1 (interrupt on completion);
  - bits 8:6 hold the memory field;
  - all other bits are 0, which selects drive zero.
- R4: For sector index s (0 to 15), the disk address is track + s, modulo 4096, and the memory address is s × 256. The sector index starts at 0 and increases by one after each good completion.
- R5: A swap without chaining issues exactly 16 go strobes. `done` is high for one cycle, in the cycle after the 16th good completion, and `busy` is low in that cycle.
- R6: A completion with `dsk_err` high raises `err` for one cycle in the next cycle, drops `busy`, and issues no further go strobe. `done` stays low.
- R7: When a swap-out finishes with a swap-in pending, the next command follows the same timing as any next sector. It uses the pending track and field with bit 11 equal to 0 and sector 0. The whole run issues 32 strobes and a single `done`.
- R8: While busy, a start pulse is ignored. The command, disk address and memory address do not change between completions. Changes on the start-setting inputs after acceptance have no effect.
- R9: A `dsk_done` pulse while idle has no effect: `busy`, `done` and `err` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| start_wr | input | 1 | 1 = swap-out (write to disk), 0 = swap-in |
| start_track | input | 12 | Track base for the first transfer |
| start_field | input | 3 | Memory field for the first transfer |
| chain_req | input | 1 | A swap-in is pending after the swap-out |
| chain_track | input | 12 | Track of the pending swap-in |
| chain_field | input | 3 | Field of the pending swap-in |
| dsk_done | input | 1 | Completion interrupt from the disk |
| dsk_err | input | 1 | Error status, valid with `dsk_done` |
| cmd | output | 12 | Disk command word |
| dsk_addr | output | 12 | Disk sector address |
| mem_addr | output | 12 | Memory address within the field |
| go | output | 1 | Command start strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Swap finished pulse |
| err | output | 1 | Swap aborted pulse |

## Verification
After an accepted start, the command and both addresses are due one cycle later and `go` two cycles later. After each good completion, the next command is due one cycle later and its strobe two cycles later. `done` or `err` is due in the cycle right after the completion that ends the run. The bench drives its inputs on the falling edge and samples one falling edge per elapsed cycle. It steps through each swap in lock-step, so every check lands in the exact cycle in which the result must appear.

// File: rtl/swap_seq_pkg.sv
package swap_seq_pkg;
  localparam int CMD_W   = 12;
  localparam int FIELD_W = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_GO, ST_WAIT} seq_st_t;

  // bit 11 write, bit 9 interrupt enable, bits 8:6 field, drive bits zero
  function automatic logic [CMD_W-1:0] make_cmd(input logic wr,
                                                input logic [FIELD_W-1:0] fld);
    logic [CMD_W-1:0] c;
    c = '0;
    c[11]  = wr;
    c[9]   = 1'b1;
    c[8:6] = fld;
    return c;
  endfunction
endpackage

// File: rtl/swap_seq_addr.sv
module swap_seq_addr #(
  parameter int TRK_W     = 12,
  parameter int SEC_BITS  = 4,
  parameter int WORD_BITS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sec_clr,
  input  logic                          sec_adv,
  input  logic [TRK_W-1:0]              track,
  output logic                          last_sec,
  output logic [TRK_W-1:0]              dsk_addr,
  output logic [SEC_BITS+WORD_BITS-1:0] mem_addr
);
  localparam int MEM_W = SEC_BITS + WORD_BITS;

  logic [SEC_BITS-1:0] sec;

  function automatic logic [TRK_W-1:0] sector_addr(input logic [TRK_W-1:0] t,
                                                    input logic [SEC_BITS-1:0] s);
    return t + {{(TRK_W-SEC_BITS){1'b0}}, s};
  endfunction

  function automatic logic [MEM_W-1:0] sector_base(input logic [SEC_BITS-1:0] s);
    return {s, {WORD_BITS{1'b0}}};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sec <= '0;
    else if (sec_clr) sec <= '0;
    else if (sec_adv) sec <= sec + 1'b1;  // wraps to zero after the last sector
  end

  assign last_sec = (sec == {SEC_BITS{1'b1}});
  assign dsk_addr = sector_addr(track, sec);
  assign mem_addr = sector_base(sec);
endmodule

// File: rtl/swap_seq_ctrl.sv
module swap_seq_ctrl
  import swap_seq_pkg::*;
#(
  parameter int TRK_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_wr,
  input  logic [TRK_W-1:0]   start_track,
  input  logic [FIELD_W-1:0] start_field,
  input  logic               chain_req,
  input  logic [TRK_W-1:0]   chain_track,
  input  logic [FIELD_W-1:0] chain_field,
  input  logic               dsk_done,
  input  logic               dsk_err,
  input  logic               last_sec,
  output logic               cur_wr,
  output logic [TRK_W-1:0]   cur_track,
  output logic [FIELD_W-1:0] cur_field,
  output logic               go,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               sec_clr,
  output logic               sec_adv,
  output logic               evt_accept,
  output logic               evt_chain
);
  seq_st_t             st;
  logic                pend;
  logic [TRK_W-1:0]    pend_track;
  logic [FIELD_W-1:0]  pend_field;
  logic                evt_good, evt_bad, evt_fin;

  assign evt_accept = (st == ST_IDLE) && start;
  assign evt_good   = (st == ST_WAIT) && dsk_done && !dsk_err;
  assign evt_bad    = (st == ST_WAIT) && dsk_done && dsk_err;
  assign evt_fin    = evt_good && last_sec;
  assign evt_chain  = evt_fin && cur_wr && pend;

  assign sec_clr = evt_accept || evt_bad;
  assign sec_adv = evt_good;
  assign go      = (st == ST_GO);
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      done       <= 1'b0;
      err        <= 1'b0;
      cur_wr     <= 1'b0;
      cur_track  <= '0;
      cur_field  <= '0;
      pend       <= 1'b0;
      pend_track <= '0;
      pend_field <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          cur_wr     <= start_wr;
          cur_track  <= start_track;
          cur_field  <= start_field;
          pend       <= start_wr && chain_req;
          pend_track <= chain_track;
          pend_field <= chain_field;
          st         <= ST_ISSUE;
        end
        ST_ISSUE: st <= ST_GO;
        ST_GO:    st <= ST_WAIT;
        ST_WAIT: if (dsk_done) begin
          if (dsk_err) begin
            err <= 1'b1;
            st  <= ST_IDLE;
          end else if (!last_sec) begin
            st <= ST_ISSUE;
          end else if (cur_wr && pend) begin
            cur_wr    <= 1'b0;
            cur_track <= pend_track;
            cur_field <= pend_field;
            pend      <= 1'b0;
            st        <= ST_ISSUE;
          end else begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swap_seq.sv
module swap_seq
  import swap_seq_pkg::*;
#(
  parameter int TRK_W     = 12,
  parameter int SEC_BITS  = 4,
  parameter int WORD_BITS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          start_wr,
  input  logic [TRK_W-1:0]              start_track,
  input  logic [FIELD_W-1:0]            start_field,
  input  logic                          chain_req,
  input  logic [TRK_W-1:0]              chain_track,
  input  logic [FIELD_W-1:0]            chain_field,
  input  logic                          dsk_done,
  input  logic                          dsk_err,
  output logic [CMD_W-1:0]              cmd,
  output logic [TRK_W-1:0]              dsk_addr,
  output logic [SEC_BITS+WORD_BITS-1:0] mem_addr,
  output logic                          go,
  output logic                          busy,
  output logic                          done,
  output logic                          err
);
  logic               cur_wr;
  logic [TRK_W-1:0]   cur_track;
  logic [FIELD_W-1:0] cur_field;
  logic               last_sec, sec_clr, sec_adv;
  logic               evt_accept, evt_chain;

  swap_seq_ctrl #(.TRK_W(TRK_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr),
    .start_track(start_track), .start_field(start_field),
    .chain_req(chain_req), .chain_track(chain_track), .chain_field(chain_field),
    .dsk_done(dsk_done), .dsk_err(dsk_err), .last_sec(last_sec),
    .cur_wr(cur_wr), .cur_track(cur_track), .cur_field(cur_field),
    .go(go), .busy(busy), .done(done), .err(err),
    .sec_clr(sec_clr), .sec_adv(sec_adv),
    .evt_accept(evt_accept), .evt_chain(evt_chain)
  );

  swap_seq_addr #(.TRK_W(TRK_W), .SEC_BITS(SEC_BITS), .WORD_BITS(WORD_BITS)) i_addr (
    .clk(clk), .rst_n(rst_n), .sec_clr(sec_clr), .sec_adv(sec_adv),
    .track(cur_track), .last_sec(last_sec),
    .dsk_addr(dsk_addr), .mem_addr(mem_addr)
  );

  assign cmd = make_cmd(cur_wr, cur_field);
endmodule

// File: rtl/swap_seq_chk.sv
module swap_seq_chk #(
  parameter int TRK_W    = 12,
  parameter int SEC_BITS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             dsk_done,
  input logic [11:0]      cmd,
  input logic [TRK_W-1:0] dsk_addr,
  input logic             evt_accept,
  input logic             evt_chain
);
  localparam int NSEC = 1 << SEC_BITS;
  logic [SEC_BITS+1:0] go_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       go_cnt <= '0;
    else if (evt_accept || evt_chain) go_cnt <= '0;
    else if (go && go_cnt <= (SEC_BITS+2)'(NSEC)) go_cnt <= go_cnt + 1'b1;
  end

  assert_go_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
  assert_go_after_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> $past(busy) && $stable(cmd) && $stable(dsk_addr));
  assert_cmd_fixed_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cmd[9] && !cmd[10] && (cmd[5:0] == 6'd0));
  assert_go_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    go_cnt <= (SEC_BITS+2)'(NSEC));
  assert_end_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  assert_err_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !go);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dsk_done) |=> (!busy || ($stable(cmd) && $stable(dsk_addr))));
  assert_idle_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && dsk_done) |=> !busy && !done && !err);
endmodule

bind swap_seq swap_seq_chk #(.TRK_W(TRK_W), .SEC_BITS(SEC_BITS)) i_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done), .err(err),
  .dsk_done(dsk_done), .cmd(cmd), .dsk_addr(dsk_addr),
  .evt_accept(evt_accept), .evt_chain(evt_chain)
);

// File: tb/test_swap_seq.sv
module test_swap_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, start_wr = 1'b0, chain_req = 1'b0;
  logic [11:0] start_track = '0, chain_track = '0;
  logic [2:0]  start_field = '0, chain_field = '0;
  logic        dsk_done = 1'b0, dsk_err = 1'b0;
  logic [11:0] cmd, dsk_addr, mem_addr;
  logic        go, busy, done, err;

  int checks = 0;
  int fails  = 0;
  int go_seen = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  swap_seq i_swap_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr),
    .start_track(start_track), .start_field(start_field),
    .chain_req(chain_req), .chain_track(chain_track), .chain_field(chain_field),
    .dsk_done(dsk_done), .dsk_err(dsk_err),
    .cmd(cmd), .dsk_addr(dsk_addr), .mem_addr(mem_addr),
    .go(go), .busy(busy), .done(done), .err(err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (go) go_seen <= go_seen + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", fails, checks + 1);
      $finish;
    end
  end

  function automatic logic [11:0] exp_cmd(input bit wr, input logic [2:0] f);
    return (12'(wr) << 11) | 12'h200 | (12'(f) << 6);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_swap(input bit wr, input logic [11:0] trk, input logic [2:0] fld,
                          input bit pend, input logic [11:0] ptrk, input logic [2:0] pfld,
                          input int err_at, input bit poke);
    int phases;
    int n;
    int base;
    phases = (wr && pend) ? 2 : 1;
    n = 0;
    @(negedge clk);
    base = go_seen;
    start = 1'b1; start_wr = wr; start_track = trk; start_field = fld;
    chain_req = pend; chain_track = ptrk; chain_field = pfld;
    @(negedge clk);
    start = 1'b0;
    start_wr = ~wr; start_track = 12'($urandom); start_field = 3'($urandom);
    chain_track = 12'($urandom); chain_field = 3'($urandom); chain_req = ~pend;
    for (int p = 0; p < phases; p++) begin
      bit          pw;
      logic [11:0] t;
      logic [2:0]  f;
      pw = (p == 0) ? wr : 1'b0;
      t  = (p == 0) ? trk : ptrk;
      f  = (p == 0) ? fld : pfld;
      for (int s = 0; s < 16; s++) begin
        int d;
        bit e;
        chk(busy && !go, "R2 valid-before-go", {busy, go}, 2'b10);
        chk(cmd == exp_cmd(pw, f), (p == 1) ? "R7 chained cmd" : "R3 cmd", cmd, exp_cmd(pw, f));
        chk(dsk_addr == 12'(t + s), "R4 disk addr", dsk_addr, 12'(t + s));
        chk(mem_addr == 12'(s * 256), "R4 mem addr", mem_addr, 12'(s * 256));
        @(negedge clk);
        chk(go == 1'b1, "R2 go strobe", go, 1);
        @(negedge clk);
        chk(go == 1'b0, "R2 go single", go, 0);
        d = $urandom_range(0, 3);
        for (int k = 0; k < d; k++) begin
          if (poke) start = 1'b1;
          @(negedge clk);
          start = 1'b0;
          chk(!go && busy && cmd == exp_cmd(pw, f) && dsk_addr == 12'(t + s),
              "R8 hold while busy", dsk_addr, 12'(t + s));
        end
        e = (n == err_at);
        dsk_done = 1'b1; dsk_err = e;
        @(negedge clk);
        dsk_done = 1'b0; dsk_err = 1'b0;
        n++;
        if (e) begin
          chk(err && !busy && !done, "R6 abort", {err, busy, done}, 3'b100);
          @(negedge clk);
          chk(!err && !go && !busy, "R6 no resume", {err, go, busy}, 3'b000);
          @(negedge clk);
          chk(go_seen - base == n, "R6 strobe count", go_seen - base, n);
          return;
        end
      end
    end
    chk(done && !busy && !err, (phases == 2) ? "R7 done once" : "R5 done",
        {done, busy, err}, 3'b100);
    @(negedge clk);
    chk(!done && !go, "R5 done pulse", {done, go}, 2'b00);
    chk(go_seen - base == 16 * phases, (phases == 2) ? "R7 strobe count" : "R5 strobe count",
        go_seen - base, 16 * phases);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk(!busy && !go && !done && !err, "R1 reset", {busy, go, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !go && !done && !err, "R1 after release", {busy, go, done, err}, 0);

    dsk_done = 1'b1;
    @(negedge clk);
    dsk_done = 1'b0;
    chk(!busy && !done && !err, "R9 stray completion", {busy, done, err}, 0);
    @(negedge clk);
    chk(!busy && !done && !err && !go, "R9 still idle", {busy, done, err}, 0);

    run_swap(1'b0, 12'o0020, 3'd2, 1'b0, 12'd0, 3'd0, -1, 1'b0);  // plain swap-in
    run_swap(1'b1, 12'o0100, 3'd5, 1'b0, 12'd0, 3'd0, -1, 1'b1);  // swap-out, pokes
    run_swap(1'b1, 12'o0200, 3'd1, 1'b1, 12'o0300, 3'd6, -1, 1'b1); // chained R7
    run_swap(1'b0, 12'hFF8, 3'd7, 1'b1, 12'o0400, 3'd3, -1, 1'b0); // wraps, no chain on read
    run_swap(1'b1, 12'o0040, 3'd4, 1'b0, 12'd0, 3'd0, 0, 1'b0);   // error on first
    run_swap(1'b1, 12'o0500, 3'd3, 1'b1, 12'o0600, 3'd2, 20, 1'b0); // error mid-chain
    run_swap(1'b0, 12'o0060, 3'd0, 1'b0, 12'd0, 3'd0, 15, 1'b0);  // error on last
    for (int i = 0; i < 6; i++) begin
      int ea;
      ea = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 31)) : -1;
      run_swap(1'($urandom), 12'($urandom), 3'($urandom), 1'($urandom),
               12'($urandom), 3'($urandom), ea, 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule